// File: doc/BRIEF.md
# Shift, Rotate and Truncating Power-of-Two Divide Unit

A purely combinational 32-bit datapath element that takes an operand, an 8-bit amount and a 3-bit operation code, and returns one result in the same cycle. It covers three shift directions and fill rules, two rotate directions, and a signed divide by 2^k whose result matches integer division that truncates toward zero. It is meant to sit beside the adder in an execute stage, where a compiler-style `x / 2^k` on a signed value has to land in one operation and not in a shift plus a fix-up sequence.

All variants share one right-going logarithmic barrel. Left-going operations reverse the bit order on the way in and on the way out. The divide adds a bias of 2^k−1 ahead of the barrel, and only when the operand is negative, then shifts arithmetically. The amount is reduced to its low five bits, so an amount of 32 or more wraps around. It does not clear the result.

Top module: `shift_div_unit`

## Requirements
- R1: Code 3'b000 is a logical right shift by k: vacated high bits are 0.
- R2: Code 3'b001 is an arithmetic right shift by k: vacated high bits copy operand bit 31, so negative values round toward minus infinity.
- R3: Code 3'b010 is a left shift by k: vacated low bits are 0.
- R4: Code 3'b011 rotates right by k: bits leaving bit 0 re-enter at bit 31.
- R5: Code 3'b100 rotates left by k: bits leaving bit 31 re-enter at bit 0.
- R6: Code 3'b101 returns the signed quotient operand / 2^k truncated toward zero, for every k from 0 to 31. A bias of 2^k−1 is added only when operand bit 31 is set, and a non-negative operand is shifted unchanged.
- R7: In divide mode, −32 with k=5 gives −1 (0xFFFFFFFF), and the most negative operand 0x80000000 gives −2^(31−k).
- R8: k is amount bits [4:0]. Bits [7:5] have no effect, so amounts of 32 and above wrap (32 acts as 0, 37 acts as 5).
- R9: Codes 3'b110 and 3'b111 pass the operand to the result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand / dividend |
| amt_i | input | 8 | Shift, rotate or divide exponent; low 5 bits used |
| op_i | input | 3 | Operation code |
| res_o | output | 32 | Result |

## Verification
The divide mode is driven hardest. The bench covers every k with negative operands whose discarded low bits are non-zero, the most negative value, and −32/32. A divider that always biases, never biases, or shifts logically would return values that are off by one toward minus infinity, or huge positive values such as 134217727. Amounts of 32, 37 and 255 check the wrap: a design that saturated would clear the result, and one that used too many bits would shift the wrong distance. Rotates at k=0 and k=31 catch off-by-one edge wiring, and the reserved codes show whether an undecoded operation leaks a shifted value.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [2:0] {
    OP_SRL  = 3'd0,
    OP_SRA  = 3'd1,
    OP_SLL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_DIV  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shu_op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } shu_fill_e;

endpackage

// File: rtl/shu_bitrev.sv
module shu_bitrev #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign dout_o[i] = din_i[WIDTH-1-i];
  end

endmodule

// File: rtl/shu_bias.sv
module shu_bias #(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [SHW-1:0]   k_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] low_mask;

  // 2^k - 1 as a run of k ones
  assign low_mask = ~({WIDTH{1'b1}} << k_i);

  // Negative dividends only; a negative plus a bias below 2^(WIDTH-1) cannot overflow
  assign sum_o = (en_i && opnd_i[WIDTH-1]) ? (opnd_i + low_mask) : opnd_i;

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic [SHW-1:0]   k_i,
  input  shu_fill_e        fill_i,
  output logic [WIDTH-1:0] dout_o
);

  logic [SHW:0][WIDTH-1:0] stg;
  logic                    fill_bit;
  logic                    wrap;

  assign fill_bit = (fill_i == FILL_SIGN) ? din_i[WIDTH-1] : 1'b0;
  assign wrap     = (fill_i == FILL_WRAP);
  assign stg[0]   = din_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int DIST = 1 << s;
    logic [WIDTH-1:0] moved;
    assign moved = wrap ? {stg[s][DIST-1:0], stg[s][WIDTH-1:DIST]}
                        : {{DIST{fill_bit}}, stg[s][WIDTH-1:DIST]};
    assign stg[s+1] = k_i[s] ? moved : stg[s];
  end

  assign dout_o = stg[SHW];

endmodule

// File: rtl/shift_div_unit.sv
module shift_div_unit
  import shu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  localparam int SHW = $clog2(WIDTH);

  shu_op_e          op;
  logic [SHW-1:0]   k;
  logic             unused_amt_hi;
  logic             go_left;
  logic             is_div;
  logic             is_pass;
  shu_fill_e        fill;
  logic [WIDTH-1:0] opnd_rev;
  logic [WIDTH-1:0] biased;
  logic [WIDTH-1:0] bar_in;
  logic [WIDTH-1:0] bar_out;
  logic [WIDTH-1:0] bar_out_rev;

  assign op            = shu_op_e'(op_i);
  assign k             = amt_i[SHW-1:0];
  assign unused_amt_hi = ^amt_i[AMT_W-1:SHW];

  always_comb begin
    go_left = 1'b0;
    is_div  = 1'b0;
    is_pass = 1'b0;
    fill    = FILL_ZERO;
    unique case (op)
      OP_SRL:  fill = FILL_ZERO;
      OP_SRA:  fill = FILL_SIGN;
      OP_SLL:  go_left = 1'b1;
      OP_ROR:  fill = FILL_WRAP;
      OP_ROL:  begin go_left = 1'b1; fill = FILL_WRAP; end
      OP_DIV:  begin is_div = 1'b1; fill = FILL_SIGN; end
      default: is_pass = 1'b1;
    endcase
  end

  shu_bitrev #(.WIDTH(WIDTH)) u_rev_in (
    .din_i  (opnd_i),
    .dout_o (opnd_rev)
  );

  shu_bias #(.WIDTH(WIDTH), .SHW(SHW)) u_bias (
    .opnd_i (opnd_i),
    .k_i    (k),
    .en_i   (is_div),
    .sum_o  (biased)
  );

  assign bar_in = go_left ? opnd_rev : biased;

  shu_barrel #(.WIDTH(WIDTH), .SHW(SHW)) u_barrel (
    .din_i  (bar_in),
    .k_i    (k),
    .fill_i (fill),
    .dout_o (bar_out)
  );

  shu_bitrev #(.WIDTH(WIDTH)) u_rev_out (
    .din_i  (bar_out),
    .dout_o (bar_out_rev)
  );

  always_comb begin
    if (is_pass)      res_o = opnd_i;
    else if (go_left) res_o = bar_out_rev;
    else              res_o = bar_out;
  end

endmodule

// File: rtl/shift_div_unit_chk.sv
module shift_div_unit_chk #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o
);

  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0] kk;
  assign kk = amt_i[SHW-1:0];

  always_comb begin
    if (op_i == 3'd0 && kk != '0)
      AST_SRL_TOP_CLEAR: assert (res_o[WIDTH-1] == 1'b0);                 // R1
    if (op_i == 3'd1)
      AST_SRA_KEEPS_SIGN: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1]);     // R2
    if (op_i == 3'd2 && kk != '0)
      AST_SLL_LOW_CLEAR: assert (res_o[0] == 1'b0);                       // R3
    if (op_i == 3'd3)
      AST_ROR_BITS_KEPT: assert ($countones(res_o) == $countones(opnd_i)); // R4
    if (op_i == 3'd4)
      AST_ROL_BITS_KEPT: assert ($countones(res_o) == $countones(opnd_i)); // R5
    if (op_i == 3'd5 && !opnd_i[WIDTH-1])
      AST_DIV_POS_NONNEG: assert (res_o[WIDTH-1] == 1'b0);                // R6
    if (op_i == 3'd5 && opnd_i[WIDTH-1] && res_o != '0)
      AST_DIV_NEG_SIGN: assert (res_o[WIDTH-1] == 1'b1);                  // R6
    if (op_i == 3'd6 || op_i == 3'd7)
      AST_RSV_PASS: assert (res_o == opnd_i);                             // R9
  end

endmodule

bind shift_div_unit shift_div_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .opnd_i (opnd_i),
  .amt_i  (amt_i),
  .op_i   (op_i),
  .res_o  (res_o)
);

// File: tb/shift_div_unit_tb.sv
module shift_div_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] opnd;
  logic [7:0]  amt;
  logic [2:0]  op;
  logic [31:0] res;
  int          n_chk;
  int          n_bad;
  bit          finished;

  shift_div_unit u_dut (
    .opnd_i (opnd),
    .amt_i  (amt),
    .op_i   (op),
    .res_o  (res)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x,
                                        input logic [7:0] a);
    int          k;
    longint      sx;
    longint      dv;
    logic [63:0] dbl;
    k   = int'(a[4:0]);
    sx  = longint'($signed(x));
    dv  = longint'(1) << k;
    dbl = {x, x};
    case (o)
      3'd0:    return x >> k;
      3'd1:    return 32'($signed(x) >>> k);
      3'd2:    return x << k;
      3'd3:    return dbl[k +: 32];
      3'd4:    return dbl[(32 - k) % 32 +: 32];
      3'd5:    return 32'(sx / dv);
      default: return x;
    endcase
  endfunction

  task automatic check(input logic [2:0] o, input logic [31:0] x,
                       input logic [7:0] a, input string req);
    logic [31:0] exp;
    @(posedge clk);
    #2;
    op   = o;
    opnd = x;
    amt  = a;
    exp  = model(o, x, a);
    @(negedge clk);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d x=%h amt=%0d actual=%h expected=%h",
               req, o, x, a, res, exp);
    end
  endtask

  task automatic check_val(input logic [2:0] o, input logic [31:0] x,
                           input logic [7:0] a, input logic [31:0] exp,
                           input string req);
    @(posedge clk);
    #2;
    op   = o;
    opnd = x;
    amt  = a;
    @(negedge clk);
    n_chk++;
    if (res !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d x=%h amt=%0d actual=%h expected=%h",
               req, o, x, a, res, exp);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    n_chk    = 0;
    n_bad    = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    opnd     = '0;
    amt      = '0;
    op       = '0;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // idle state: zero operand gives zero result
    check_val(3'd0, 32'h0, 8'd0, 32'h0, "R1");

    // R1 / R2 / R3 directed
    check_val(3'd0, 32'h8000_0000, 8'd31, 32'h0000_0001, "R1");
    check_val(3'd1, 32'h8000_0000, 8'd31, 32'hFFFF_FFFF, "R2");
    check_val(3'd1, 32'hFFFF_FFFB, 8'd1,  32'hFFFF_FFFD, "R2");
    check_val(3'd2, 32'h0000_0003, 8'd31, 32'h8000_0000, "R3");
    // R4 / R5 edges
    check_val(3'd3, 32'h0000_0001, 8'd1,  32'h8000_0000, "R4");
    check_val(3'd3, 32'h1234_5678, 8'd0,  32'h1234_5678, "R4");
    check_val(3'd4, 32'h8000_0000, 8'd1,  32'h0000_0001, "R5");
    check_val(3'd4, 32'h0000_0001, 8'd31, 32'h8000_0000, "R5");
    // R7 corner values
    check_val(3'd5, 32'hFFFF_FFE0, 8'd5,  32'hFFFF_FFFF, "R7");
    check_val(3'd5, 32'hFFFF_FFE1, 8'd5,  32'h0000_0000, "R7");
    check_val(3'd5, 32'h8000_0000, 8'd31, 32'hFFFF_FFFF, "R7");
    check_val(3'd5, 32'h8000_0000, 8'd0,  32'h8000_0000, "R7");
    check_val(3'd5, 32'hFFFF_FFFF, 8'd31, 32'h0000_0000, "R6");
    check_val(3'd5, 32'h7FFF_FFFF, 8'd31, 32'h0000_0000, "R6");
    // R8 amount wrap
    check_val(3'd0, 32'hF000_000F, 8'd32,  32'hF000_000F, "R8");
    check_val(3'd0, 32'hF000_000F, 8'd37,  32'h0780_0000, "R8");
    check_val(3'd2, 32'h0000_0001, 8'd255, 32'h8000_0000, "R8");
    check_val(3'd5, 32'hFFFF_FFE0, 8'd229, 32'hFFFF_FFFF, "R8");
    // R9 reserved codes
    check_val(3'd6, 32'hDEAD_BEEF, 8'd7, 32'hDEAD_BEEF, "R9");
    check_val(3'd7, 32'hCAFE_F00D, 8'd3, 32'hCAFE_F00D, "R9");

    // R6 every k: most negative, random negative with low bits, random positive
    for (int k = 0; k < 32; k++) begin
      check(3'd5, 32'h8000_0000, 8'(k), "R7");
      r = $urandom | 32'h8000_0001;
      check(3'd5, r, 8'(k), "R6");
      r = $urandom & 32'h7FFF_FFFF;
      check(3'd5, r, 8'(k), "R6");
    end

    // constrained random over every code
    for (int i = 0; i < 2400; i++) begin
      logic [2:0] o;
      logic [7:0] a;
      o = 3'(i % 8);
      a = 8'($urandom);
      r = $urandom;
      if (i % 5 == 0) r = r | 32'h8000_0000;
      case (o)
        3'd0: check(o, r, a, "R1");
        3'd1: check(o, r, a, "R2");
        3'd2: check(o, r, a, "R3");
        3'd3: check(o, r, a, "R4");
        3'd4: check(o, r, a, "R5");
        3'd5: check(o, r, a, "R6");
        default: check(o, r, a, "R9");
      endcase
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule